// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a large set of level-sensitive interrupt request lines and folds them into a smaller set of group request lines for a parent interrupt controller. The inputs are split into groups of eight. Each group produces one output line, which is the OR of the inputs in that group that are both enabled and asserted. The number of groups is a parameter. By default there are 20 groups, which gives 160 inputs and 20 outputs.

Software controls the enables through a small register port. Each cycle the port accepts one read strobe or one write strobe. Four neighbouring groups share a 32-bit register bank. Each bank has these registers:
- A set port: writing ones turns enables on.
- A clear port: writing ones turns enables off.
- A status view: it shows the enabled inputs that are currently high.

Because the enables never need a read-modify-write, software handlers that share the block cannot lose each other's updates. Read data comes from a register. It appears on the cycle after the read strobe and holds until the next read.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset, every enable bit is 0, every `grp_irq` line is 0 and `reg_rdata` is 0.
- R2: `grp_irq[g]` is high exactly when some input `irq_src[8*g+k]` (k = 0..7) is high and its enable bit is set. The output is combinational, with no register between input and output.
- R3: Bank b decodes at byte address 0x10*b, and bank b = g/4 holds group g. Input i = 8*g+k maps to bit i%32 of its bank's registers, so group g occupies bits 8*(g%4)+7 down to 8*(g%4).
- R4: A write to bank offset 0x0 sets every enable bit whose `reg_wdata` bit is 1. Enable bits whose `reg_wdata` bit is 0 keep their value. The change is visible from the next clock edge.
- R5: A write to bank offset 0x4 clears every enable bit whose `reg_wdata` bit is 1. All other enable bits keep their value.
- R6: A read of bank offset 0x0 returns the bank's 32 enable bits.
- R7: A read of bank offset 0xC returns the bank's input bits ANDed with its enable bits. These status bits are taken at the clock edge of the read and are never latched: once an input falls, its status bit reads 0.
- R8: Read data is loaded at the clock edge where `reg_rd` is high. It holds its value through every cycle in which `reg_rd` is low.
- R9: Reads return 0 at offset 0x4, at any offset other than 0x0, 0x4 or 0xC, and at any bank number of NUM_GROUPS/4 (rounded up) or more. Writes to any address other than the set and clear offsets of an existing bank leave every enable bit and every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_GROUPS*8 | Level-sensitive interrupt inputs |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 32 | Registered read data |
| grp_irq | output | NUM_GROUPS | One combined request per group |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that `irq_src` changes only between clock edges and stays steady around the sampling edge. The bench drives every input on the falling edge and issues exactly one access per strobe pulse, so both assumptions hold. The random stimulus draws addresses from the mapped offsets, the unmapped offsets and bank numbers past the last bank. It draws data and input patterns from the full 32-bit range, so every enable bit and every group line is exercised.

// File: rtl/comb_pkg.sv
package comb_pkg;
    localparam int GRP_SRCS       = 8;
    localparam int GRPS_PER_BANK  = 4;
    localparam int BANK_BITS      = GRP_SRCS * GRPS_PER_BANK;
    localparam int BANK_STRIDE_LSB = 4;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_EN_SET,
        REG_EN_CLR,
        REG_STATUS
    } reg_kind_e;
endpackage

// File: rtl/comb_addr_decode.sv
module comb_addr_decode
    import comb_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = ADDR_W - BANK_STRIDE_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        bank = addr[ADDR_W-1:BANK_STRIDE_LSB];
        kind = REG_NONE;
        if (int'(bank) < NUM_BANKS) begin
            unique case (addr[BANK_STRIDE_LSB-1:0])
                4'h0:    kind = REG_EN_SET;
                4'h4:    kind = REG_EN_CLR;
                4'hC:    kind = REG_STATUS;
                default: kind = REG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/comb_bank.sv
module comb_bank
    import comb_pkg::*;
#(
    parameter int GROUPS_HERE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [BANK_BITS-1:0]     src,
    input  logic                     set_we,
    input  logic                     clr_we,
    input  logic [BANK_BITS-1:0]     wdata,
    output logic [BANK_BITS-1:0]     en_o,
    output logic [BANK_BITS-1:0]     stat_o,
    output logic [GRPS_PER_BANK-1:0] grp_o
);
    localparam int LIVE_BITS = GROUPS_HERE * GRP_SRCS;
    localparam logic [BANK_BITS-1:0] LIVE_MASK =
        (LIVE_BITS >= BANK_BITS) ? {BANK_BITS{1'b1}}
                                 : BANK_BITS'((64'd1 << LIVE_BITS) - 64'd1);

    logic [BANK_BITS-1:0] en_q;
    logic [BANK_BITS-1:0] en_d;

    // clear wins if both strobes ever arrive together
    always_comb begin
        en_d = en_q;
        if (set_we) en_d = en_d | wdata;
        if (clr_we) en_d = en_d & ~wdata;
        en_d = en_d & LIVE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o   = en_q;
    assign stat_o = src & en_q;

    for (genvar g = 0; g < GRPS_PER_BANK; g++) begin : g_grp
        assign grp_o[g] = |stat_o[g*GRP_SRCS +: GRP_SRCS];

        // R2: a group line needs at least one raised input in that group
        a_r2_out_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
            grp_o[g] |-> (|src[g*GRP_SRCS +: GRP_SRCS]));
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0));

    a_r4_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((en_q & $past(en_q)) == $past(en_q)));

    a_r5_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((en_q & $past(wdata)) == '0));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import comb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*GRP_SRCS-1:0] irq_src,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [31:0]                  reg_wdata,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    output logic [31:0]                  reg_rdata,
    output logic [NUM_GROUPS-1:0]        grp_irq
);
    localparam int NUM_BANKS = (NUM_GROUPS + GRPS_PER_BANK - 1) / GRPS_PER_BANK;
    localparam int BANK_W    = ADDR_W - BANK_STRIDE_LSB;
    localparam int PAD_W     = NUM_BANKS * BANK_BITS;
    localparam int GRP_PAD   = NUM_BANKS * GRPS_PER_BANK;

    reg_kind_e            kind;
    logic [BANK_W-1:0]    bank_idx;
    logic [PAD_W-1:0]     src_pad;
    logic [NUM_BANKS-1:0] set_vec;
    logic [NUM_BANKS-1:0] clr_vec;
    logic [BANK_BITS-1:0] en_all   [NUM_BANKS];
    logic [BANK_BITS-1:0] stat_all [NUM_BANKS];
    logic [GRP_PAD-1:0]   grp_all;
    logic [31:0]          rd_val;

    assign src_pad = PAD_W'(irq_src);

    comb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W)
    ) u_dec (
        .addr(reg_addr),
        .kind(kind),
        .bank(bank_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LEFT = NUM_GROUPS - b * GRPS_PER_BANK;
        localparam int HERE = (LEFT > GRPS_PER_BANK) ? GRPS_PER_BANK : LEFT;

        assign set_vec[b] = reg_wr && (kind == REG_EN_SET) && (bank_idx == BANK_W'(b));
        assign clr_vec[b] = reg_wr && (kind == REG_EN_CLR) && (bank_idx == BANK_W'(b));

        comb_bank #(.GROUPS_HERE(HERE)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src_pad[b*BANK_BITS +: BANK_BITS]),
            .set_we(set_vec[b]),
            .clr_we(clr_vec[b]),
            .wdata (reg_wdata),
            .en_o  (en_all[b]),
            .stat_o(stat_all[b]),
            .grp_o (grp_all[b*GRPS_PER_BANK +: GRPS_PER_BANK])
        );
    end

    assign grp_irq = grp_all[NUM_GROUPS-1:0];

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_W'(b)) begin
                unique case (kind)
                    REG_EN_SET: rd_val = en_all[b];
                    REG_STATUS: rd_val = stat_all[b];
                    default:    rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    a_r3_one_bank_set: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec | clr_vec));

    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (kind == REG_NONE || kind == REG_EN_CLR)) |=> (reg_rdata == '0));
endmodule

// File: tb/sim_irq_group_combiner.sv
module sim_irq_group_combiner;
    localparam int NG    = 20;
    localparam int NS    = NG * 8;
    localparam int NB    = (NG + 3) / 4;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_src = '0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [31:0]   reg_rdata;
    logic [NG-1:0] grp_irq;

    logic [NB*32-1:0] exp_en = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .grp_irq(grp_irq)
    );

    function automatic logic [NG-1:0] model_grp();
        logic [NG-1:0] r;
        logic [NB*32-1:0] s;
        s = (NB*32)'(irq_src) & exp_en;
        for (int g = 0; g < NG; g++) r[g] = |s[g*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int b;
        logic [NB*32-1:0] s;
        b = int'(a >> 4);
        s = (NB*32)'(irq_src) & exp_en;
        if (b >= NB) return 32'h0;
        case (a[3:0])
            4'h0:    return exp_en[b*32 +: 32];
            4'hC:    return s[b*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        int b;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        b = int'(a >> 4);
        if (b < NB && a[3:0] == 4'h0) exp_en[b*32 +: 32] = exp_en[b*32 +: 32] | d;
        if (b < NB && a[3:0] == 4'h4) exp_en[b*32 +: 32] = exp_en[b*32 +: 32] & ~d;
    endtask

    task automatic rd_chk(string req, logic [AW-1:0] a);
        logic [31:0] e;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        e = model_read(a);
        @(negedge clk);
        reg_rd = 1'b0;
        chk(req, reg_rdata, e);
    endtask

    task automatic drive_src(logic [NS-1:0] v);
        @(negedge clk);
        irq_src = v;
        #1;
    endtask

    task automatic chk_grp(string req);
        chk(req, 32'(grp_irq), 32'(model_grp()));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 grp after reset", 32'(grp_irq), 32'h0);
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) rd_chk("R1 enable zero", AW'(b*16));
        drive_src('1);
        chk("R1 no enable no output", 32'(grp_irq), 32'h0);
        drive_src('0);

        wr(8'h00, 32'h0000_00A5);
        rd_chk("R6 readback", 8'h00);
        wr(8'h00, 32'h0000_0F00);
        rd_chk("R4 set keeps others", 8'h00);
        wr(8'h04, 32'h0000_0005);
        rd_chk("R5 clear", 8'h04 - 8'h04);

        wr(8'h40, 32'hFF00_0000);
        drive_src(NS'(1) << 159);
        chk("R3 group 19 line", 32'(grp_irq), 32'h0008_0000);
        rd_chk("R3 status bit 31 bank 4", 8'h4C);
        chk("R7 status value", reg_rdata, 32'h8000_0000);
        drive_src('0);
        rd_chk("R7 no latching", 8'h4C);
        chk("R7 status dropped", reg_rdata, 32'h0);

        drive_src(NS'(1) << 9);
        chk("R2 group 1 line", 32'(grp_irq), 32'h0000_0002);
        drive_src(NS'(1) << 17);
        chk("R2 disabled input", 32'(grp_irq), 32'h0);

        rd_chk("R8 load", 8'h00);
        held = reg_rdata;
        repeat (3) @(negedge clk);
        chk("R8 hold", reg_rdata, held);

        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        rd_chk("R9 enable untouched", 8'h00);
        chk("R9 enable value", reg_rdata, 32'h0000_0FA0);
        rd_chk("R9 offset 8 reads zero", 8'h08);
        rd_chk("R9 clear port reads zero", 8'h04);
        rd_chk("R9 bank past end", 8'h50);
        chk("R9 outputs unchanged", 32'(grp_irq), 32'h0);

        for (int i = 0; i < 500; i++) begin
            int op;
            logic [AW-1:0] a;
            op = int'($urandom_range(0, 4));
            a  = AW'({$urandom_range(0, NB), 2'(($urandom_range(0, 3))), 2'b00});
            case (op)
                0: wr(a, $urandom());
                1: wr(AW'($urandom_range(0, NB-1) * 16), $urandom());
                2: wr(AW'($urandom_range(0, NB-1) * 16 + 4), $urandom());
                3: rd_chk("R6 R7 R9 random read", a);
                default: begin
                    logic [NS-1:0] v;
                    for (int k = 0; k < NS/32; k++) v[k*32 +: 32] = $urandom() & $urandom();
                    drive_src(v);
                end
            endcase
            chk_grp("R2 random");
        end
        summary();
    end
endmodule